// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Parallel Preset

This block is a wide synchronous binary counter assembled from identical narrow slices. Each slice holds a few bits and has a count enable, a direction select and a synchronous parallel preset. Each slice also produces a rollover flag, and that flag enables the next slice up.

Every register in every slice is clocked by the same clock. Only the enables ripple through combinational logic, and no register is clocked from the output of another. The default build chains five 4-bit slices into a 20-bit counter.

The counter can count up or down, hold its value, or be loaded with any value in one clock. The final rollover comes out as a port, so a wider counter can be built by chaining more of these blocks.

Top module: `updn_cascade_counter`

## Requirements
- R1: With `cnt_en`=1, `load`=0 and `dir_up`=1, each rising clock edge sets `count` to (count + 1) modulo 2^20.
- R2: With `cnt_en`=1, `load`=0 and `dir_up`=0, each rising clock edge sets `count` to (count - 1) modulo 2^20.
- R3: With `cnt_en`=0 and `load`=0, `count` keeps its value across clock edges.
- R4: `carry_out` is combinational. It equals 1 exactly when `cnt_en`=1, `load`=0, and `count` is at its terminal value for the selected direction. The terminal value is all ones when `dir_up`=1 and all zeros when `dir_up`=0.
- R5: A slice advances only when every slice below it is at its terminal value and `cnt_en`=1, so a carry or borrow crosses slice boundaries on the same edge.
- R6: With `load`=1, the next rising edge copies `preset` into `count`, whatever `cnt_en` and `dir_up` are. Counting resumes on the first edge after `load` returns to 0.
- R7: While `load`=1, `carry_out` is 0, even when `count` is at a terminal value.
- R8: Counting up from 0xFFFFF gives 0x00000, and counting down from 0x00000 gives 0xFFFFF.
- R9: While `rst_n`=0, `count` is 0 (asynchronous active-low reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all slices |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable for the lowest slice |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| load | input | 1 | Synchronous parallel preset strobe |
| preset | input | 20 | Value copied into the counter on load |
| count | output | 20 | Current counter value |
| carry_out | output | 1 | Rollover of the top slice, for further chaining |

## Verification
Directed sequences come first:
- A preset of 0x0000F stepped up, and 0x00010 stepped down, shows whether a carry or borrow crosses a slice boundary.
- Presets at 0xFFFFF and 0x00000 separate correct wrapping from saturation or sign errors.
- A load applied at a terminal value shows whether loading takes priority and whether it suppresses the rollover.

A long random run follows. It mixes enable, direction and load, and it biases presets toward values just below a slice boundary. Every cycle, the run compares `count` and `carry_out` with a plain integer model.

// File: rtl/updn_pkg.sv
package updn_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } count_dir_e;
endpackage

// File: rtl/updn_toggle_mask.sv
module updn_toggle_mask #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] q,
    input  updn_pkg::count_dir_e dir,
    output logic [SLICE_W-1:0] tmask,
    output logic               term
);
    // Bit 0 always toggles. Bit i toggles when all lower bits are at the
    // direction's terminal level: ones going up, zeros going down.
    assign tmask[0] = 1'b1;
    generate
        for (genvar i = 1; i < SLICE_W; i++) begin : g_mask
            assign tmask[i] = (dir == updn_pkg::DIR_UP) ? (&q[i-1:0]) : ~(|q[i-1:0]);
        end
    endgenerate

    assign term = (dir == updn_pkg::DIR_UP) ? (&q) : ~(|q);
endmodule

// File: rtl/updn_slice.sv
module updn_slice #(
    parameter int SLICE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en,
    input  logic               dir_up,
    input  logic               load,
    input  logic [SLICE_W-1:0] preset,
    output logic [SLICE_W-1:0] q,
    output logic               roll
);
    typedef struct packed {
        logic [SLICE_W-1:0] q;
    } slice_state_t;

    slice_state_t       st_d, st_q;
    logic [SLICE_W-1:0] tmask;
    logic               term;
    updn_pkg::count_dir_e dir;

    assign dir = dir_up ? updn_pkg::DIR_UP : updn_pkg::DIR_DOWN;

    updn_toggle_mask #(.SLICE_W(SLICE_W)) mask_i (
        .q     (st_q.q),
        .dir   (dir),
        .tmask (tmask),
        .term  (term)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.q = preset;
        end else if (cnt_en) begin
            st_d.q = st_q.q ^ tmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q    = st_q.q;
    assign roll = cnt_en & term & ~load;

    assert_inc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && dir_up && !load) |=> (q == SLICE_W'($past(q) + 1'b1)));

    assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !dir_up && !load) |=> (q == SLICE_W'($past(q) - 1'b1)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load) |=> $stable(q));

    assert_roll_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        roll |-> cnt_en);

    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(preset)));

    assert_no_roll_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !roll);
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter #(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cnt_en,
    input  logic                          dir_up,
    input  logic                          load,
    input  logic [SLICE_W*NUM_SLICES-1:0] preset,
    output logic [SLICE_W*NUM_SLICES-1:0] count,
    output logic                          carry_out
);
    localparam int TOTAL_W = SLICE_W * NUM_SLICES;
    localparam logic [TOTAL_W-1:0] ALL_ONES = '1;

    // en_chain[k] enables slice k; en_chain[NUM_SLICES] is the final rollover.
    logic [NUM_SLICES:0] en_chain;

    assign en_chain[0] = cnt_en;

    generate
        for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
            updn_slice #(.SLICE_W(SLICE_W)) slice_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .cnt_en (en_chain[k]),
                .dir_up (dir_up),
                .load   (load),
                .preset (preset[k*SLICE_W +: SLICE_W]),
                .q      (count[k*SLICE_W +: SLICE_W]),
                .roll   (en_chain[k+1])
            );
        end
    endgenerate

    assign carry_out = en_chain[NUM_SLICES];

    assert_wrap_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && dir_up && !load && count == ALL_ONES) |=> (count == '0));

    assert_wrap_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !dir_up && !load && count == '0) |=> (count == ALL_ONES));

    assert_chain_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && dir_up && !load && count != ALL_ONES) |=> (count == TOTAL_W'($past(count) + 1'b1)));
endmodule

// File: tb/updn_cascade_counter_tb.sv
module updn_cascade_counter_tb_top;
    localparam int W = 20;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic         dir_up = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] preset = '0;
    logic [W-1:0] count;
    logic         carry_out;

    int total = 0;
    int bad = 0;
    int ref_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    updn_cascade_counter dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_up(dir_up),
        .load(load), .preset(preset), .count(count), .carry_out(carry_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Drive inputs at negedge, check carry, advance the model, then check
    // the count at the next negedge.
    task automatic step(input bit en, input bit up, input bit ld, input int pv, input string req);
        int exp_carry;
        cnt_en = en; dir_up = up; load = ld; preset = W'(pv);
        #1;
        exp_carry = (en && !ld && (up ? ref_cnt == MAXV : ref_cnt == 0)) ? 1 : 0;
        check(ld ? "R7" : "R4", int'(carry_out), exp_carry);
        if (ld)      ref_cnt = pv & MAXV;
        else if (en) ref_cnt = up ? ((ref_cnt + 1) & MAXV) : ((ref_cnt - 1) & MAXV);
        @(negedge clk);
        check(req, int'(count), ref_cnt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", int'(count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", int'(count), 0);

        step(1, 1, 0, 0, "R1");
        step(1, 1, 0, 0, "R1");
        step(0, 1, 0, 0, "R3");
        step(0, 0, 0, 0, "R3");
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R8");          // 0 -> FFFFF
        step(0, 1, 1, 'h0000F, "R6");
        step(1, 1, 0, 0, "R5");          // 0000F -> 00010
        step(1, 0, 0, 0, "R5");          // 00010 -> 0000F
        step(1, 1, 1, 'hFFFFF, "R6");    // load wins over counting
        step(1, 1, 1, 'hFFFFF, "R7");    // terminal while loading: no carry
        step(1, 1, 0, 0, "R8");          // FFFFF -> 0
        step(1, 1, 1, 'h0FFFF, "R6");
        step(1, 1, 0, 0, "R5");          // carry through four slices
        step(1, 0, 0, 0, "R5");          // borrow back

        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            int pv;
            case ($urandom_range(0, 2))
                0: pv = int'($urandom) & MAXV;
                1: pv = MAXV - $urandom_range(0, 3);
                default: pv = $urandom_range(0, 3);
            endcase
            if (r < 6)       step($urandom_range(0, 1), $urandom_range(0, 1), 1, pv, "R6");
            else if (r < 20) step(0, $urandom_range(0, 1), 0, pv, "R3");
            else if ($urandom_range(0, 1) == 1) step(1, 1, 0, pv, "R1");
            else             step(1, 0, 0, pv, "R2");
        end

        rst_n = 1'b0;
        #1;
        check("R9", int'(count), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule